// File: doc/BRIEF.md
# Video Sync Presence and Horizontal Lock Detector

This block follows the horizontal sync indication of a video decoder front end, one pulse per line, and judges it against a line-period counter that runs on its own. Each sync is classed as on time when it lands within one clock of the predicted point, and as early when it lands before that. When no sync comes by the end of the window, the line is counted as missed. From this line-by-line record the block derives two live status flags: one says a video signal is present, the other says the decoder is in horizontal lock. Both flags use hysteresis over many lines, so a single bad or missing sync does not toggle them.

The nominal line length, in sample clocks, is an input, so one build serves several line standards. An early sync realigns the counter, so the next prediction is taken from that sync. A missed line keeps the counter on its nominal grid. A one-cycle strobe marks each line event for downstream logic. Both flags are plain status that follows the input and is never held for software to clear.

Top module: `sync_lock_detect`

## Requirements
- R1: During and after a synchronous reset, `vid_present`, `h_locked` and `line_strobe` are 0 and the line counter restarts from the start of a line.
- R2: With a sync at cycle t (or a virtual line boundary at t), a sync at cycle t+L-1, t+L or t+L+1 (L = `line_len`) counts as on time. When no sync comes through cycle t+L+1, that cycle is a missed line and the next virtual boundary is t+L.
- R3: `h_locked` rises in the cycle after the 32nd consecutive on-time sync.
- R4: Once `h_locked` is 1, it falls in the cycle after the 32nd consecutive missed line, where a missed line is an early sync or a window with no sync.
- R5: A sync before cycle t+L-1 is early. It realigns the counter, so the next window is measured from that sync.
- R6: `vid_present` is 1 in the cycle after any sync, whether on time or early.
- R7: `vid_present` falls in the cycle after the 31st consecutive line period that ends with no sync.
- R8: A missed line clears the run of on-time syncs, and an on-time sync clears the run of missed lines. Lock and unlock each need an unbroken run of 32.
- R9: `line_strobe` is a one-cycle pulse in the cycle after every line event: any sync or any window end with no sync.
- R10: `line_len` is taken at run time. Any value of at least 4 that fits the counter width works, and a new value governs the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | One-cycle pulse when horizontal sync is detected |
| line_len | input | CNT_W | Nominal line period in clocks (at least 4) |
| vid_present | output | 1 | Video present status, live |
| h_locked | output | 1 | Horizontal lock status, live |
| line_strobe | output | 1 | One-cycle pulse after each line event |

## Verification
The bench keeps the default thresholds of 32 lines for lock and unlock and 31 lines for absence, with a 12-bit counter. The line length is set to 20 clocks for most of the run, so each hysteresis run takes a few hundred cycles and many lock, unlock and absence transitions fit in one short run. A later phase switches to 64 clocks, which shows the length is read at run time and that a change moves the window. Sync spacings of L-2, L-1, L, L+1 and half of L place pulses on both edges of the window and just outside it.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
  typedef enum logic [1:0] {
    LN_NONE    = 2'd0,
    LN_HIT     = 2'd1,
    LN_EARLY   = 2'd2,
    LN_TIMEOUT = 2'd3
  } line_ev_e;
endpackage

// File: rtl/sdet_line_timer.sv
module sdet_line_timer
  import sdet_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] line_len,
  output line_ev_e         ev_o
);
  // pos counts clocks since the last line boundary, 0 in the cycle after it
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] win_lo;
  logic             in_win;
  logic             win_end;

  assign win_lo  = line_len - CNT_W'(2);
  assign in_win  = (pos >= win_lo);
  assign win_end = (pos >= line_len);

  always_comb begin
    ev_o = LN_NONE;
    if (sync_in) ev_o = in_win ? LN_HIT : LN_EARLY;
    else if (win_end) ev_o = LN_TIMEOUT;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (sync_in) pos <= '0;
    else if (win_end) pos <= CNT_W'(1);
    else pos <= pos + CNT_W'(1);
  end

  p_realign_r5: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> (pos == '0));
  p_wrap_grid_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_o == LN_TIMEOUT) |=> (pos == CNT_W'(1)));
endmodule

// File: rtl/sdet_run_lock.sv
module sdet_run_lock
  import sdet_pkg::*;
#(
  parameter int LOCK_LINES = 32
) (
  input  logic     clk,
  input  logic     rst,
  input  line_ev_e ev_i,
  output logic     locked_o
);
  localparam int RW = $clog2(LOCK_LINES + 1);
  localparam logic [RW-1:0] RMAX = RW'(LOCK_LINES);

  logic [RW-1:0] hit_run, miss_run, hit_nxt, miss_nxt;
  logic          is_hit, is_miss;

  assign is_hit  = (ev_i == LN_HIT);
  assign is_miss = (ev_i == LN_EARLY) || (ev_i == LN_TIMEOUT);

  always_comb begin
    hit_nxt  = hit_run;
    miss_nxt = miss_run;
    if (is_hit) begin
      hit_nxt  = (hit_run == RMAX) ? RMAX : hit_run + RW'(1);
      miss_nxt = '0;
    end else if (is_miss) begin
      miss_nxt = (miss_run == RMAX) ? RMAX : miss_run + RW'(1);
      hit_nxt  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_run  <= '0;
      miss_run <= '0;
      locked_o <= 1'b0;
    end else begin
      hit_run  <= hit_nxt;
      miss_run <= miss_nxt;
      if (locked_o) locked_o <= (miss_nxt != RMAX);
      else          locked_o <= (hit_nxt == RMAX);
    end
  end

  p_lock_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> (hit_run == RMAX));
  p_lock_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> (miss_run == RMAX));
  p_runs_excl_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_run == '0) || (miss_run == '0));
  p_run_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_run <= RMAX) && (miss_run <= RMAX));
endmodule

// File: rtl/sdet_presence.sv
module sdet_presence
  import sdet_pkg::*;
#(
  parameter int ABSENT_LINES = 31
) (
  input  logic     clk,
  input  logic     rst,
  input  line_ev_e ev_i,
  output logic     present_o
);
  localparam int AW = $clog2(ABSENT_LINES + 1);
  localparam logic [AW-1:0] AMAX = AW'(ABSENT_LINES);

  logic [AW-1:0] quiet_run, quiet_nxt;
  logic          saw_sync;

  assign saw_sync = (ev_i == LN_HIT) || (ev_i == LN_EARLY);

  always_comb begin
    quiet_nxt = quiet_run;
    if (saw_sync) quiet_nxt = '0;
    else if (ev_i == LN_TIMEOUT)
      quiet_nxt = (quiet_run == AMAX) ? AMAX : quiet_run + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_run <= '0;
      present_o <= 1'b0;
    end else begin
      quiet_run <= quiet_nxt;
      if (saw_sync) present_o <= 1'b1;
      else if (quiet_nxt == AMAX) present_o <= 1'b0;
    end
  end

  p_present_set_r6: assert property (@(posedge clk) disable iff (rst)
    saw_sync |=> present_o);
  p_present_clr_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(present_o) |-> (quiet_run == AMAX));
endmodule

// File: rtl/sync_lock_detect.sv
module sync_lock_detect
  import sdet_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int LOCK_LINES   = 32,
  parameter int ABSENT_LINES = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] line_len,
  output logic             vid_present,
  output logic             h_locked,
  output logic             line_strobe
);
  line_ev_e ev;

  sdet_line_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .sync_in(sync_in), .line_len(line_len), .ev_o(ev)
  );

  sdet_run_lock #(.LOCK_LINES(LOCK_LINES)) u_lock (
    .clk(clk), .rst(rst), .ev_i(ev), .locked_o(h_locked)
  );

  sdet_presence #(.ABSENT_LINES(ABSENT_LINES)) u_pres (
    .clk(clk), .rst(rst), .ev_i(ev), .present_o(vid_present)
  );

  always_ff @(posedge clk) begin
    if (rst) line_strobe <= 1'b0;
    else     line_strobe <= (ev != LN_NONE);
  end

  p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (ev != LN_NONE) |=> line_strobe);
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (ev == LN_NONE) |=> !line_strobe);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!vid_present && !h_locked && !line_strobe) || rst);
endmodule

// File: tb/sync_lock_detect_tb.sv
module sync_lock_detect_tb;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sync_in = 1'b0;
  logic [CNT_W-1:0] line_len = CNT_W'(20);
  logic             vid_present, h_locked, line_strobe;

  int total = 0;
  int bad   = 0;

  // behavioural model state
  int  age = 0;
  int  hits = 0, misses = 0, quiet = 0;
  bit  m_pres = 0, m_lock = 0, m_strobe = 0;

  always #5 clk = ~clk;

  sync_lock_detect #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .line_len(line_len),
    .vid_present(vid_present), .h_locked(h_locked), .line_strobe(line_strobe)
  );

  always @(posedge clk) begin
    int L;
    bit on_time, missed, no_sync;
    L = int'(line_len);
    if (rst) begin
      age = 0; hits = 0; misses = 0; quiet = 0;
      m_pres = 0; m_lock = 0; m_strobe = 0;
    end else begin
      on_time = 0; missed = 0; no_sync = 0;
      if (sync_in) begin
        if (age >= L - 2) on_time = 1; else missed = 1;
        age = 0;
      end else if (age >= L) begin
        missed = 1; no_sync = 1; age = 1;
      end else age = age + 1;
      m_strobe = sync_in || no_sync;
      if (on_time) begin hits = (hits < 32) ? hits + 1 : 32; misses = 0; end
      if (missed)  begin misses = (misses < 32) ? misses + 1 : 32; hits = 0; end
      if (m_lock) m_lock = (misses < 32); else m_lock = (hits == 32);
      if (sync_in) quiet = 0;
      else if (no_sync) quiet = (quiet < 31) ? quiet + 1 : 31;
      if (sync_in) m_pres = 1; else if (quiet == 31) m_pres = 0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic step(input bit s);
    @(negedge clk);
    chk("R6/R7 vid_present", vid_present, m_pres);
    chk("R3/R4/R8 h_locked", h_locked, m_lock);
    chk("R9 line_strobe", line_strobe, m_strobe);
    sync_in = s;
  endtask

  task automatic syncs(input int period, input int count);
    for (int k = 0; k < count; k++) begin
      for (int i = 0; i < period - 1; i++) step(1'b0);
      step(1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) step(1'b0);
        // R1: reset state held
        chk("R1 present at reset", vid_present, 1'b0);
        chk("R1 lock at reset", h_locked, 1'b0);
        chk("R1 strobe at reset", line_strobe, 1'b0);
        @(negedge clk); rst = 1'b0;
        idle(70);                                 // R2 timeouts, R7 stays absent
        chk("R7 absent with no sync", vid_present, 1'b0);
        syncs(20, 31);                            // R3 one short of 32 on-time
        chk("R3 not yet locked", h_locked, 1'b0);
        chk("R6 present after sync", vid_present, 1'b1);
        syncs(20, 3);
        chk("R3 locked", h_locked, 1'b1);
        syncs(19, 8); syncs(21, 8);               // R2 window edges keep lock
        chk("R2 edges on time", h_locked, 1'b1);
        syncs(18, 1);                             // R5 early at L-2
        syncs(20, 4);
        chk("R8 hit run cleared, lock kept", h_locked, 1'b1);
        syncs(10, 31);                            // R5/R4 early syncs
        chk("R4 not yet unlocked", h_locked, 1'b1);
        syncs(10, 2);
        chk("R4 unlocked", h_locked, 1'b0);
        syncs(20, 20); syncs(10, 1); syncs(20, 31); // R8 broken run
        chk("R8 run restart", h_locked, 1'b0);
        syncs(20, 2);
        chk("R8 lock after unbroken run", h_locked, 1'b1);
        idle(20 * 30 + 5);                        // R7 30 empty lines
        chk("R7 present before 31", vid_present, 1'b1);
        idle(40);
        chk("R7 absent after 31", vid_present, 1'b0);
        chk("R4 unlock by missing lines", h_locked, 1'b0);
        @(negedge clk); line_len = CNT_W'(64);    // R10 new length
        syncs(64, 40);
        chk("R10 lock at 64", h_locked, 1'b1);
        syncs(20, 40);
        chk("R10 short lines are early", h_locked, 1'b0);
        @(negedge clk); rst = 1'b1;
        step(1'b0); step(1'b0);
        chk("R1 reset clears lock", h_locked, 1'b0);
        chk("R1 reset clears present", vid_present, 1'b0);
      end
      begin
        while (wd < 100000) begin @(posedge clk); wd++; end
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule